// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog timer. A free-running timebase counter advances on every clock and can be read back, so software can confirm that the clock is alive. A separate interval counter measures watchdog periods of 2^N clocks while the watchdog is armed. Arming takes two enable keys that sit in two different control words, so a single stray write cannot start or stop the timer.

Expiry happens in two stages. The first interval overflow sets a state flag and raises a level interrupt. If the state flag is still set when the next overflow arrives, the block issues a reset request pulse of fixed length and records that a reset happened. Software services the timer by writing ones to the two status flags. That write clears them and restarts the interval. An optional build-time lock makes the watchdog impossible to stop once it has run.

The block is reached through a simple 32-bit bus with separate read and write strobes. Read data is registered and appears on the cycle after the read strobe.

Top module: `tbwd_top`

## Requirements
- R1: Word address 0x0 is control word A, 0x4 is control word B and 0x8 is the read-only timebase count. A read strobe returns the addressed word on `bus_rdata` one clock later. Bits with no defined meaning, unmapped word addresses (such as 0xC) and addresses with a nonzero low byte-offset all read as zero.
- R2: The watchdog runs only while both key bits are 1: bit 1 of word A and bit 0 of word B. While either key is 0, the state flag never sets and the interrupt stays low.
- R3: When the watchdog starts, or after a service write, the first overflow comes 2^N clocks later. It sets the state flag (word A bit 2) and drives `wdt_irq` high, with no reset request.
- R4: If an overflow occurs while the state flag is set, `wdt_rst_req` goes high for exactly RST_LEN clocks. In the same cycle the reset-occurred flag (word A bit 3) sets and the state flag clears. The interval keeps running.
- R5: Writing word A with bit 2 or bit 3 at 1 clears the matching flag and restarts the interval. Writing 0 to those bits leaves both flags unchanged and does not restart the interval.
- R6: A service write that lands on the same clock as an overflow wins. No flag is set and the interval restarts.
- R7: The timebase count increments by exactly one every clock. Writes to word 0x8 have no effect on it.
- R8: When built with ENABLE_ONCE=1, once the watchdog has run, writes of 0 to either key are ignored and the watchdog keeps running. With ENABLE_ONCE=0 such writes stop it.
- R9: Synchronous reset clears both keys, both flags, the interval and the pulse. Both outputs are then low and words A and B read zero.
- R10: Stopping the watchdog clears the interval. A later start gets a full 2^N-clock first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the clock after `bus_rd` |
| wdt_irq | output | 1 | Level interrupt, high while the state flag is set |
| wdt_rst_req | output | 1 | Reset request pulse, RST_LEN clocks long |

## Verification
The bench builds the block with an interval exponent of 4 and a reset pulse of 3 clocks. At these values the first overflow arrives 16 clocks after a start and the reset pulse begins 32 clocks after it. This puts every expiry edge, the same-cycle collision between a service write and an overflow, and the exact pulse boundaries within a few dozen clocks of exact-cycle checking. Two instances are built side by side on the same bus, one with the one-time lock and one without. The same stop writes therefore show both the stopped and the locked outcome. The timebase is left at its full 32-bit width and is checked by the differences between reads.

// File: rtl/tbwd_pkg.sv
`timescale 1ns/1ps
package tbwd_pkg;

    localparam int DATA_W = 32;

    // word indices on the register bus
    localparam int WORD_CTRL_A = 0;
    localparam int WORD_CTRL_B = 1;
    localparam int WORD_TBASE  = 2;

    // bit positions that software decodes
    localparam int BIT_KEY_B  = 0;  // in word B
    localparam int BIT_KEY_A  = 1;  // in word A
    localparam int BIT_STATE  = 2;  // in word A
    localparam int BIT_RSTAT  = 3;  // in word A

    typedef enum logic [1:0] {
        SEL_CTRL_A,
        SEL_CTRL_B,
        SEL_TBASE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic key_a;
        logic key_b;
    } keys_t;

    typedef struct packed {
        logic rstat;
        logic state;
    } stat_t;

    typedef struct packed {
        logic restart;
        logic clr_state;
        logic clr_rstat;
    } svc_t;

    function automatic reg_sel_e word_sel(input logic [31:0] word);
        reg_sel_e s;
        if (word == 32'(WORD_CTRL_A))      s = SEL_CTRL_A;
        else if (word == 32'(WORD_CTRL_B)) s = SEL_CTRL_B;
        else if (word == 32'(WORD_TBASE))  s = SEL_TBASE;
        else                               s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl_a(input stat_t s, input logic key_a);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_KEY_A] = key_a;
        w[BIT_STATE] = s.state;
        w[BIT_RSTAT] = s.rstat;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl_b(input logic key_b);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_KEY_B] = key_b;
        return w;
    endfunction

endpackage

// File: rtl/tbwd_timebase.sv
`timescale 1ns/1ps
module tbwd_timebase #(
    parameter int TB_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TB_W-1:0] tb
);
    always_ff @(posedge clk) begin
        if (rst) tb <= '0;
        else     tb <= tb + TB_W'(1);
    end
endmodule

// File: rtl/tbwd_interval.sv
`timescale 1ns/1ps
module tbwd_interval #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic ovf
);
    logic [N-1:0] cnt_q;

    // a restart on the terminal count suppresses the overflow
    assign ovf = run & ~restart & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) cnt_q <= '0;
        else                        cnt_q <= cnt_q + N'(1);
    end
endmodule

// File: rtl/tbwd_expiry.sv
`timescale 1ns/1ps
module tbwd_expiry
    import tbwd_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ovf,
    input  logic  clr_state,
    input  logic  clr_rstat,
    output stat_t stat,
    output logic  rst_req
);
    localparam int PW = $clog2(RST_LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat   <= '0;
            left_q <= '0;
        end else if (ovf && stat.state) begin
            // second stage: request reset, record it, rearm first stage
            stat.state <= 1'b0;
            stat.rstat <= 1'b1;
            left_q     <= PW'(RST_LEN);
        end else begin
            if (ovf)            stat.state <= 1'b1;
            else if (clr_state) stat.state <= 1'b0;
            if (clr_rstat)      stat.rstat <= 1'b0;
            if (left_q != '0)   left_q <= left_q - PW'(1);
        end
    end

    assign rst_req = (left_q != '0);
endmodule

// File: rtl/tbwd_regs.sv
`timescale 1ns/1ps
module tbwd_regs
    import tbwd_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int TB_W        = 32,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  stat_t             stat,
    input  logic [TB_W-1:0]   tb,
    output logic              run,
    output svc_t              svc
);
    keys_t    keys_q;
    logic     locked;
    reg_sel_e sel;
    logic     wr_a;
    logic     wr_b;
    logic     unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:4];

    assign sel  = (bus_addr[1:0] == 2'b00) ? word_sel(32'(bus_addr[ADDR_W-1:2])) : SEL_NONE;
    assign wr_a = bus_wr && (sel == SEL_CTRL_A);
    assign wr_b = bus_wr && (sel == SEL_CTRL_B);
    assign run  = keys_q.key_a & keys_q.key_b;

    generate
        if (ENABLE_ONCE) begin : g_once
            logic seen_q;
            always_ff @(posedge clk) begin
                if (rst)      seen_q <= 1'b0;
                else if (run) seen_q <= 1'b1;
            end
            assign locked = seen_q | run;
        end else begin : g_free
            assign locked = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            keys_q <= '0;
        end else begin
            if (wr_a) keys_q.key_a <= bus_wdata[BIT_KEY_A] | (locked & keys_q.key_a);
            if (wr_b) keys_q.key_b <= bus_wdata[BIT_KEY_B] | (locked & keys_q.key_b);
        end
    end

    always_comb begin
        svc.clr_state = wr_a & bus_wdata[BIT_STATE];
        svc.clr_rstat = wr_a & bus_wdata[BIT_RSTAT];
        svc.restart   = svc.clr_state | svc.clr_rstat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_CTRL_A: bus_rdata <= pack_ctrl_a(stat, keys_q.key_a);
                SEL_CTRL_B: bus_rdata <= pack_ctrl_b(keys_q.key_b);
                SEL_TBASE:  bus_rdata <= DATA_W'(tb);
                default:    bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/tbwd_top.sv
`timescale 1ns/1ps
module tbwd_top
    import tbwd_pkg::*;
#(
    parameter int INTERVAL_LOG2 = 16,
    parameter int RST_LEN       = 16,
    parameter int TB_W          = 32,
    parameter int ADDR_W        = 4,
    parameter bit ENABLE_ONCE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst_req
);
    logic            run;
    logic            ovf;
    svc_t            svc;
    stat_t           stat;
    logic [TB_W-1:0] tb_val;

    tbwd_timebase #(.TB_W(TB_W)) u_tb (
        .clk (clk),
        .rst (rst),
        .tb  (tb_val)
    );

    tbwd_regs #(
        .ADDR_W      (ADDR_W),
        .TB_W        (TB_W),
        .ENABLE_ONCE (ENABLE_ONCE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat      (stat),
        .tb        (tb_val),
        .run       (run),
        .svc       (svc)
    );

    tbwd_interval #(.N(INTERVAL_LOG2)) u_ivl (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (svc.restart),
        .ovf     (ovf)
    );

    tbwd_expiry #(.RST_LEN(RST_LEN)) u_exp (
        .clk       (clk),
        .rst       (rst),
        .ovf       (ovf),
        .clr_state (svc.clr_state),
        .clr_rstat (svc.clr_rstat),
        .stat      (stat),
        .rst_req   (wdt_rst_req)
    );

    assign wdt_irq = stat.state;
endmodule

// File: rtl/tbwd_chk.sv
`timescale 1ns/1ps
module tbwd_chk #(
    parameter int RST_LEN     = 16,
    parameter int TB_W        = 32,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic            run,
    input logic            irq,
    input logic            rst_req,
    input logic            rstat,
    input logic [TB_W-1:0] tb
);
    localparam int CW = $clog2(RST_LEN + 2);

    logic          live;
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= 1'b0;
            hi_cnt <= '0;
        end else begin
            live   <= 1'b1;
            hi_cnt <= rst_req ? hi_cnt + CW'(1) : '0;
        end
    end

    // R4: reset request only follows a cycle with the interrupt raised
    a_r4_after_irq: assert property (@(posedge clk) disable iff (rst)
        (live && $rose(rst_req)) |-> $past(irq));

    // R4: reset-occurred flag is set whenever the request starts
    a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
        (live && $rose(rst_req)) |-> rstat);

    // R4: pulse never exceeds its length
    a_r4_pulse_max: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (hi_cnt < CW'(RST_LEN)));

    // R4: pulse ends exactly at its length
    a_r4_pulse_len: assert property (@(posedge clk) disable iff (rst)
        (live && $fell(rst_req)) |-> (hi_cnt == CW'(RST_LEN)));

    // R2: the interrupt only rises out of a running cycle
    a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
        (live && $rose(irq)) |-> $past(run));

    // R7: timebase advances by one every clock
    a_r7_tb_step: assert property (@(posedge clk) disable iff (rst)
        live |-> (tb == TB_W'($past(tb) + 1'b1)));

    // R8: with the lock built in, a running watchdog never stops
    a_r8_locked: assert property (@(posedge clk) disable iff (rst)
        (ENABLE_ONCE && live && $past(run)) |-> run);
endmodule

bind tbwd_top tbwd_chk #(
    .RST_LEN     (RST_LEN),
    .TB_W        (TB_W),
    .ENABLE_ONCE (ENABLE_ONCE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .irq     (wdt_irq),
    .rst_req (wdt_rst_req),
    .rstat   (stat.rstat),
    .tb      (tb_val)
);

// File: tb/sim_tbwd_top.sv
`timescale 1ns/1ps
module sim_tbwd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        irq0, irq1, rreq0, rreq1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tbwd_top #(.INTERVAL_LOG2(4), .RST_LEN(3), .TB_W(32), .ADDR_W(4), .ENABLE_ONCE(1'b0)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .wdt_irq(irq0), .wdt_rst_req(rreq0));

    tbwd_top #(.INTERVAL_LOG2(4), .RST_LEN(3), .TB_W(32), .ADDR_W(4), .ENABLE_ONCE(1'b1)) u1 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .wdt_irq(irq1), .wdt_rst_req(rreq1));

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'h0, 32'h0,         32'h0},  // R9 reset value word A
        '{1'b0, 4'h4, 32'h0,         32'h0},  // R9 reset value word B
        '{1'b1, 4'h0, 32'hFFFF_FFF2, 32'h0},
        '{1'b0, 4'h0, 32'h0,         32'h2},  // R1 only key A reads back
        '{1'b1, 4'h4, 32'hFFFF_FFFE, 32'h0},
        '{1'b0, 4'h4, 32'h0,         32'h0},
        '{1'b1, 4'h4, 32'h1,         32'h0},
        '{1'b0, 4'h4, 32'h0,         32'h1},
        '{1'b0, 4'h5, 32'h0,         32'h0},  // R1 misaligned
        '{1'b1, 4'h0, 32'h0,         32'h0},
        '{1'b0, 4'h0, 32'h0,         32'h0},
        '{1'b0, 4'hC, 32'h0,         32'h0},  // R1 unmapped
        '{1'b1, 4'h4, 32'h0,         32'h0},
        '{1'b0, 4'h4, 32'h0,         32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // each bus task is entered at a falling edge and returns one clock later
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic start();
        wr(4'h0, 32'h2);
        wr(4'h4, 32'h1);
    endtask

    // irq of u0 must be low 15 clocks and high 16 clocks after a (re)start write
    task automatic expect_first(input string tag);
        idle(15);
        chk({tag, " irq before"}, 32'(irq0), 32'h0);
        idle(1);
        chk({tag, " irq at overflow"}, 32'(irq0), 32'h1);
        chk({tag, " no reset"}, 32'(rreq0), 32'h0);
    endtask

    initial begin
        logic [31:0] t0, t1, t2;
        @(negedge clk);
        do_reset();
        chk("R9 irq after reset", 32'(irq0), 32'h0);
        chk("R9 rst_req after reset", 32'(rreq0), 32'h0);

        // register map vectors
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) wr(VEC[i].addr, VEC[i].data);
            else begin
                rd(VEC[i].addr);
                chk($sformatf("R1 vector %0d", i), rdata0, VEC[i].exp);
            end
        end

        // R3 / R4: both expiry stages
        do_reset();
        start();
        expect_first("R3");
        idle(15);
        chk("R4 no pulse yet", 32'(rreq0), 32'h0);
        idle(1);
        chk("R4 pulse start", 32'(rreq0), 32'h1);
        chk("R4 state cleared", 32'(irq0), 32'h0);
        idle(2);
        chk("R4 pulse last", 32'(rreq0), 32'h1);
        idle(1);
        chk("R4 pulse end", 32'(rreq0), 32'h0);
        rd(4'h0);
        chk("R4 word A flags", rdata0, 32'hA);
        wr(4'h0, 32'hA);
        rd(4'h0);
        chk("R5 rstat cleared by one", rdata0, 32'h2);

        // R5: service write restarts interval, zeros leave flags
        do_reset();
        start();
        idle(9);
        wr(4'h0, 32'h6);
        expect_first("R5 restart");
        wr(4'h0, 32'h2);
        chk("R5 zero write keeps state", 32'(irq0), 32'h1);
        wr(4'h0, 32'h6);
        chk("R5 one clears state", 32'(irq0), 32'h0);

        // R6: service on the overflow clock
        do_reset();
        start();
        idle(15);
        wr(4'h0, 32'h6);
        chk("R6 collision no irq", 32'(irq0), 32'h0);
        expect_first("R6");

        // R2 / R10: stop clears the interval
        do_reset();
        start();
        idle(9);
        wr(4'h4, 32'h0);
        idle(30);
        chk("R2 stopped irq low", 32'(irq0), 32'h0);
        wr(4'h4, 32'h1);
        expect_first("R10");

        // R7: timebase
        do_reset();
        rd(4'h8); t0 = rdata0;
        rd(4'h8); t1 = rdata0;
        chk("R7 step", t1 - t0, 32'h1);
        wr(4'h8, 32'h0);
        rd(4'h8); t2 = rdata0;
        chk("R7 write ignored", t2 - t1, 32'h2);

        // R8: one-time enable lock
        do_reset();
        start();
        wr(4'h4, 32'h0);
        wr(4'h0, 32'h0);
        rd(4'h0);
        chk("R8 free A", rdata0, 32'h0);
        chk("R8 locked A", rdata1, 32'h2);
        rd(4'h4);
        chk("R8 free B", rdata0, 32'h0);
        chk("R8 locked B", rdata1, 32'h1);
        idle(11);
        chk("R8 locked irq before", 32'(irq1), 32'h0);
        idle(1);
        chk("R8 locked irq fires", 32'(irq1), 32'h1);
        chk("R8 free stays quiet", 32'(irq0), 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule